// File: doc/BRIEF.md
# Selectable Sync/Async Control Capture

This block sits between raw control pins and a routing datapath. It handles two groups of controls. The path group holds the port selects, the direction-mode fields, a word-width select and the per-port load enables for the inbound and outbound data registers. The OE group holds the active-low output enables of every I/O port. Each group has its own mode input. With the mode input low, the group's inputs pass combinationally to its outputs. With the mode input high, the outputs come from shadow registers that are clocked by the control clock.

The shadow registers load on every control-clock edge, whatever the mode is. A group that runs combinationally therefore always has a current copy in its shadow. A switch to clocked operation starts from that copy, as long as the inputs were clocked in and then held steady across the mode change. A valid flag clears on reset and sets on the first control-clock edge after reset. While the flag is low, a group in clocked mode drives safe values: every output enable high (inactive), and every path-group bit low, which includes all load enables.

Top module: `ctl_capture_top`

## Requirements
- R1: With `path_sync_i` low, every path-group output equals its input in the same cycle, with no clock edge needed. This also holds during reset.
- R2: With `path_sync_i` high and `valid_o` high, every path-group output equals the value its input had at the most recent rising edge of `clk`. The output does not change between edges.
- R3: With `oe_sync_i` low, `oe_n_o` equals `oe_n_i` in the same cycle. This also holds during reset.
- R4: With `oe_sync_i` high and `valid_o` high, `oe_n_o` equals the value `oe_n_i` had at the most recent rising edge of `clk`. The output does not change between edges.
- R5: `valid_o` is 0 after any edge taken with `rst_n` low. It stays 0 until the first rising edge taken with `rst_n` high, and it is 1 after that edge.
- R6: While `valid_o` is 0, a group in clocked mode drives safe values. Every bit of `oe_n_o` is 1 (an output enable is active when its bit is 0). Every path-group output is 0, so both load-enable vectors are all zero.
- R7: The shadow registers load on every rising edge, in either mode. When a group's mode input rises with `valid_o` high, its outputs show the inputs captured at the last edge. If the inputs were held across that edge, the outputs keep their values through the switch.
- R8: The two mode inputs act independently. Either group may be clocked while the other passes straight through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| path_sync_i | input | 1 | Path group mode: 1 = clocked, 0 = pass-through |
| oe_sync_i | input | 1 | OE group mode: 1 = clocked, 0 = pass-through |
| xsel_i | input | XSEL_W | Narrow-port source select |
| ysel_i | input | YSEL_W | Second wide-port source select |
| a_path_i | input | APATH_W | Inbound-direction path mode |
| x_path_i | input | XPATH_W | Outbound-direction path mode |
| word_mode_i | input | 1 | Wide-word routing select |
| ld_in_i | input | NPORT | Inbound register load enables, active high |
| ld_out_i | input | NPORT | Outbound register load enables, active high |
| oe_n_i | input | NOE | Output enables, active low |
| xsel_o | output | XSEL_W | Resolved narrow-port select |
| ysel_o | output | YSEL_W | Resolved second wide-port select |
| a_path_o | output | APATH_W | Resolved inbound path mode |
| x_path_o | output | XPATH_W | Resolved outbound path mode |
| word_mode_o | output | 1 | Resolved wide-word select |
| ld_in_o | output | NPORT | Resolved inbound load enables |
| ld_out_o | output | NPORT | Resolved outbound load enables |
| oe_n_o | output | NOE | Resolved output enables, active low |
| valid_o | output | 1 | Shadow registers hold sampled values |

## Verification
A group in pass-through mode produces its result in the same cycle as the stimulus. The bench changes inputs on the falling edge and compares 1 to 2 ns later, with no rising edge in between.

A group in clocked mode shows a value one rising edge after it is applied. Each table vector therefore applies value A, lets exactly one rising edge pass, applies value B, and compares before the next edge. A clocked group must then show A and a pass-through group must show B.

`valid_o` and the safe values are checked twice after reset is released: once before the first edge, and again at the falling edge that follows it. The mode switches are checked a few nanoseconds after the mode input moves, with no edge between the switch and the check.

// File: rtl/ctl_cap_pkg.sv
`timescale 1ns/1ps
// Package: ctl_cap_pkg
// Purpose : Shared field widths and the width helper for the control
//           capture block. Assumes every field has a fixed width that is
//           known at elaboration time.
package ctl_cap_pkg;
    localparam int XSEL_W_DEF  = 2;
    localparam int YSEL_W_DEF  = 1;
    localparam int APATH_W_DEF = 2;
    localparam int XPATH_W_DEF = 2;
    localparam int NPORT_DEF   = 4;
    localparam int NOE_DEF     = 6;

    // Total width of the flattened path-control group.
    function automatic int path_group_width(input int xsel_w, input int ysel_w,
                                            input int apath_w, input int xpath_w,
                                            input int nport);
        return xsel_w + ysel_w + apath_w + xpath_w + 1 + 2 * nport;
    endfunction
endpackage

// File: rtl/ctl_valid_flag.sv
`timescale 1ns/1ps
// Module : ctl_valid_flag
// Purpose: Marks when the shadow registers hold values that were sampled
//          from the inputs. The flag clears on a synchronous reset and sets
//          on the first control-clock edge taken out of reset.
// Assumes: rst_n is synchronous to clk.
module ctl_valid_flag (
    input  logic clk,
    input  logic rst_n,
    output logic valid
);
    // Set on the first edge out of reset; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= 1'b1;
    end

    // R5: an edge taken out of reset makes the flag valid.
    a_r5_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> valid);

    // R5: an edge taken in reset clears the flag.
    a_r5_valid_clr: assert property (@(posedge clk)
        !rst_n |=> !valid);
endmodule

// File: rtl/ctl_group_capture.sv
`timescale 1ns/1ps
// Module : ctl_group_capture
// Purpose: One control group. The shadow register samples the raw inputs on
//          every control-clock edge, whatever the mode, so it is already
//          primed when the group switches to clocked mode. The output mux
//          picks the raw inputs (pass-through), the shadow (clocked), or
//          SAFE (clocked, but valid not yet set).
// Assumes: sync_mode may change at any time. For a glitch-free switch,
//          raw must be held steady across the edge before the switch.
module ctl_group_capture #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   SAFE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_mode,
    input  logic         valid,
    input  logic [W-1:0] raw,
    output logic [W-1:0] res
);
    logic [W-1:0] shadow_q;

    // Sample the inputs on every edge; load SAFE while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_q <= SAFE;
        else        shadow_q <= raw;
    end

    // Pick pass-through, the shadow copy, or the safe value.
    always_comb begin
        if (!sync_mode)  res = raw;
        else if (!valid) res = SAFE;
        else             res = shadow_q;
    end

    // R2/R4/R7: in clocked mode with valid set, the output shows the input
    // from the previous edge, also on the first cycle after a mode switch.
    a_r2_r4_follow_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && valid) |-> (res == $past(raw)));

    // R6: a clocked group drives SAFE until valid is set.
    a_r6_safe_until_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !valid) |-> (res == SAFE));
endmodule

// File: rtl/ctl_capture_top.sv
`timescale 1ns/1ps
// Module : ctl_capture_top
// Purpose: Resolves two control groups between raw pins and a routing
//          datapath. The path group holds the selects, path modes, word
//          select and load enables. The OE group holds the active-low output
//          enables. Each group has its own pass-through / clocked mode input.
// Assumes: a single control clock; rst_n is synchronous to it.
module ctl_capture_top
    import ctl_cap_pkg::*;
#(
    parameter int XSEL_W  = XSEL_W_DEF,
    parameter int YSEL_W  = YSEL_W_DEF,
    parameter int APATH_W = APATH_W_DEF,
    parameter int XPATH_W = XPATH_W_DEF,
    parameter int NPORT   = NPORT_DEF,
    parameter int NOE     = NOE_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               path_sync_i,
    input  logic               oe_sync_i,
    input  logic [XSEL_W-1:0]  xsel_i,
    input  logic [YSEL_W-1:0]  ysel_i,
    input  logic [APATH_W-1:0] a_path_i,
    input  logic [XPATH_W-1:0] x_path_i,
    input  logic               word_mode_i,
    input  logic [NPORT-1:0]   ld_in_i,
    input  logic [NPORT-1:0]   ld_out_i,
    input  logic [NOE-1:0]     oe_n_i,
    output logic [XSEL_W-1:0]  xsel_o,
    output logic [YSEL_W-1:0]  ysel_o,
    output logic [APATH_W-1:0] a_path_o,
    output logic [XPATH_W-1:0] x_path_o,
    output logic               word_mode_o,
    output logic [NPORT-1:0]   ld_in_o,
    output logic [NPORT-1:0]   ld_out_o,
    output logic [NOE-1:0]     oe_n_o,
    output logic               valid_o
);
    localparam int PATH_W = path_group_width(XSEL_W, YSEL_W, APATH_W, XPATH_W, NPORT);
    localparam logic [PATH_W-1:0] PATH_SAFE = '0;
    localparam logic [NOE-1:0]    OE_SAFE   = '1;

    logic [PATH_W-1:0] path_raw;
    logic [PATH_W-1:0] path_res;
    logic              valid;

    // Flatten the path-group pins into one vector for capture.
    assign path_raw = {xsel_i, ysel_i, a_path_i, x_path_i, word_mode_i, ld_in_i, ld_out_i};

    // Split the resolved path-group vector back into named outputs.
    assign {xsel_o, ysel_o, a_path_o, x_path_o, word_mode_o, ld_in_o, ld_out_o} = path_res;

    assign valid_o = valid;

    ctl_valid_flag u_valid (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (valid)
    );

    ctl_group_capture #(
        .W    (PATH_W),
        .SAFE (PATH_SAFE)
    ) u_path_grp (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (path_sync_i),
        .valid     (valid),
        .raw       (path_raw),
        .res       (path_res)
    );

    ctl_group_capture #(
        .W    (NOE),
        .SAFE (OE_SAFE)
    ) u_oe_grp (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (oe_sync_i),
        .valid     (valid),
        .raw       (oe_n_i),
        .res       (oe_n_o)
    );

    // R6: no load enable is active from a clocked path group before valid is set.
    a_r6_loads_low: assert property (@(posedge clk) disable iff (!rst_n)
        (path_sync_i && !valid_o) |-> (ld_in_o == '0 && ld_out_o == '0));

    // R6: every output enable is inactive from a clocked OE group before valid is set.
    a_r6_oe_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_sync_i && !valid_o) |-> (&oe_n_o));

    // R8: a pass-through OE group follows its pins while the path group is clocked.
    a_r8_oe_independent: assert property (@(posedge clk) disable iff (!rst_n)
        (path_sync_i && !oe_sync_i) |-> (oe_n_o == oe_n_i));
endmodule

// File: tb/ctl_capture_top_tb_top.sv
`timescale 1ns/1ps
// Bench: a table walk of mode/stimulus vectors, then directed tests for
// reset, the valid flag and mode switching.
module ctl_capture_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        path_sync, oe_sync;
    logic [15:0] path_in;
    logic [5:0]  oe_in;
    logic [15:0] path_out;
    logic [5:0]  oe_out;
    logic        valid_o;
    logic [1:0]  xsel_o, a_path_o, x_path_o;
    logic [0:0]  ysel_o;
    logic        word_mode_o;
    logic [3:0]  ld_in_o, ld_out_o;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    ctl_capture_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .path_sync_i (path_sync),
        .oe_sync_i   (oe_sync),
        .xsel_i      (path_in[15:14]),
        .ysel_i      (path_in[13:13]),
        .a_path_i    (path_in[12:11]),
        .x_path_i    (path_in[10:9]),
        .word_mode_i (path_in[8]),
        .ld_in_i     (path_in[7:4]),
        .ld_out_i    (path_in[3:0]),
        .oe_n_i      (oe_in),
        .xsel_o      (xsel_o),
        .ysel_o      (ysel_o),
        .a_path_o    (a_path_o),
        .x_path_o    (x_path_o),
        .word_mode_o (word_mode_o),
        .ld_in_o     (ld_in_o),
        .ld_out_o    (ld_out_o),
        .oe_n_o      (oe_out),
        .valid_o     (valid_o)
    );

    assign path_out = {xsel_o, ysel_o, a_path_o, x_path_o, word_mode_o, ld_in_o, ld_out_o};

    // Entry layout: {path mode, oe mode, path A, oe A, path B, oe B}.
    localparam logic [45:0] TBL [6] = '{
        {1'b0, 1'b0, 16'h1234, 6'h2A, 16'h8E71, 6'h15},
        {1'b1, 1'b1, 16'hA5C3, 6'h3C, 16'h5A3C, 6'h03},
        {1'b1, 1'b0, 16'h0F0F, 6'h01, 16'hF0F0, 6'h3E},
        {1'b0, 1'b1, 16'hFFFF, 6'h00, 16'h0000, 6'h3F},
        {1'b1, 1'b1, 16'h0001, 6'h20, 16'h8000, 6'h1F},
        {1'b0, 1'b1, 16'hC3A5, 6'h11, 16'h3C5A, 6'h22}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; path_sync = 1'b1; oe_sync = 1'b1;
        path_in = 16'h7E81; oe_in = 6'h0C;

        // Reset with both groups clocked: flag low, safe values (R5, R6).
        repeat (2) @(negedge clk);
        #2;
        chk("R5 valid in reset", {31'd0, valid_o}, 32'd0);
        chk("R6 oe safe", {26'd0, oe_out}, 32'h3F);
        chk("R6 path safe", {16'd0, path_out}, 32'h0);
        // Pass-through during reset (R1, R3).
        path_sync = 1'b0; oe_sync = 1'b0;
        #1;
        chk("R1 path bypass in reset", {16'd0, path_out}, 32'h7E81);
        chk("R3 oe bypass in reset", {26'd0, oe_out}, 32'h0C);

        // Release reset: no edge yet, so still invalid and safe (R5, R6).
        @(negedge clk);
        path_sync = 1'b1; oe_sync = 1'b1; path_in = 16'h1357; oe_in = 6'h29; rst_n = 1'b1;
        #2;
        chk("R5 valid before first edge", {31'd0, valid_o}, 32'd0);
        chk("R6 oe safe before first edge", {26'd0, oe_out}, 32'h3F);
        @(negedge clk);
        #2;
        chk("R5 valid after first edge", {31'd0, valid_o}, 32'd1);
        chk("R2 path captured", {16'd0, path_out}, 32'h1357);
        chk("R4 oe captured", {26'd0, oe_out}, 32'h29);

        // Clocked outputs hold between edges (R2, R4).
        path_in = 16'h2468; oe_in = 6'h06;
        #2;
        chk("R2 path holds between edges", {16'd0, path_out}, 32'h1357);
        chk("R4 oe holds between edges", {26'd0, oe_out}, 32'h29);
        @(negedge clk);
        #2;
        chk("R2 path next edge", {16'd0, path_out}, 32'h2468);
        chk("R4 oe next edge", {26'd0, oe_out}, 32'h06);

        // Table walk: a clocked group shows A, a pass-through group shows B (R1-R4; mixed rows R8).
        for (int i = 0; i < 6; i++) begin
            logic        ps, os;
            logic [15:0] pa, pb;
            logic [5:0]  oa, ob;
            string       rp, ro;
            {ps, os, pa, oa, pb, ob} = TBL[i];
            @(negedge clk);
            path_sync = ps; oe_sync = os; path_in = pa; oe_in = oa;
            @(negedge clk);
            path_in = pb; oe_in = ob;
            #2;
            rp = ps ? "R2" : "R1";
            ro = os ? "R4" : "R3";
            if (ps != os) begin
                rp = {rp, "+R8"};
                ro = {ro, "+R8"};
            end
            chk($sformatf("%s path row %0d", rp, i), {16'd0, path_out}, {16'd0, ps ? pa : pb});
            chk($sformatf("%s oe row %0d", ro, i), {26'd0, oe_out}, {26'd0, os ? oa : ob});
        end

        // R7: the shadow loaded while in pass-through; the switch shows the last capture.
        @(negedge clk);
        path_sync = 1'b0; oe_sync = 1'b0; path_in = 16'h9ABC; oe_in = 6'h33;
        @(negedge clk);
        path_in = 16'h4321; oe_in = 6'h0A;
        #1;
        path_sync = 1'b1; oe_sync = 1'b1;
        #1;
        chk("R7 path shadow primed", {16'd0, path_out}, 32'h9ABC);
        chk("R7 oe shadow primed", {26'd0, oe_out}, 32'h33);

        // R7: inputs clocked and held, so the switch keeps the same output.
        @(negedge clk);
        path_sync = 1'b0; oe_sync = 1'b0; path_in = 16'h5555; oe_in = 6'h2D;
        @(negedge clk);
        #1;
        path_sync = 1'b1; oe_sync = 1'b1;
        #1;
        chk("R7 path steady switch", {16'd0, path_out}, 32'h5555);
        chk("R7 oe steady switch", {26'd0, oe_out}, 32'h2D);

        // Reset during operation: the flag drops and safe values return (R5, R6).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #2;
        chk("R5 valid cleared by reset", {31'd0, valid_o}, 32'd0);
        chk("R6 oe safe after reset", {26'd0, oe_out}, 32'h3F);
        chk("R6 loads low after reset", {24'd0, ld_in_o, ld_out_o}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule